// File: doc/BRIEF.md
# Serial GPIO Shift Master

This block extends a set of internal general-purpose pins over a four-wire serial link to external shift-register devices. Every serial position carries one output bit (driven from a cached output register) and one input bit (captured into an input value register), so a frame moves both directions at once. The pin count is programmed in groups of eight, and the serial clock comes from the bus clock through a programmable divider.

Software programs a control word holding the divider, the group count and an enable, and writes the output cache. While enabled, the block repeats frames back to back. Each frame is a load pulse followed by the shifted bits, highest position first. Captured inputs become visible only once a whole frame has been received, so a read never returns a partly updated input word.

Top module: `serial_gpio_master`

## Requirements
- R1: The control word places the 16-bit divider in bits [31:16], the group count (pins / 8) in bits [6 +: CNT_W], and the enable in bit 0. It reads back as written, and every other bit reads 0. The register address uses its top two bits to select a region: 0 control, 1 output cache, 2 input values. The low bits select a 32-bit word.
- R2: While the enable is 0, sclk, sload and sdout stay low and no frame runs.
- R3: Once enabled, sclk starts low and every sclk level lasts exactly divider + 1 bus clocks, so one serial period is 2 × (divider + 1).
- R4: Every frame starts with sload high for exactly one serial period. sload falls on the same bus clock edge as an sclk falling edge.
- R5: After the load period, groups × 8 bits are shifted out on sdout. The first bit is the output cache bit at position groups × 8 − 1, and the rest follow downward to position 0. sdout changes only on sclk falling edges, so it is stable at each rising edge.
- R6: sdin is sampled at each sclk rising edge. The k-th sampled bit of a frame (counting from 0) lands at position groups × 8 − 1 − k of the input value register.
- R7: The input value register changes only when a frame completes. Disabling the block in mid-frame discards the bits captured so far.
- R8: Input positions at or above groups × 8 keep their previous values when a frame completes.
- R9: A write to the output cache region is read back unchanged, with positions above the pin maximum reading 0, and appears on par_out. Writes to the input value region have no effect.
- R10: While enabled, frames follow one another with no gap. Load pulses repeat every (groups × 8 + 1) × 2 × (divider + 1) bus clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Region (top two bits) and word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock |
| sload | output | 1 | Load pulse, active high |
| sdout | output | 1 | Serial data to the external devices |
| sdin | input | 1 | Serial data from the external devices |
| par_out | output | MAX_PINS | Cached output values |
| par_in | output | MAX_PINS | Input values from the last complete frame |

## Verification
The bench builds the block with CNT_W = 2. This gives a 24-pin maximum that fits a single register word. A group count of three then exercises a full-width frame, and smaller counts leave upper positions for the retention check. Frames run with dividers of 0, 1 and 2. The divider of 0 gives the shortest half period of one bus clock, where the sclk edges and the sload edges are closest together. Group counts of 1, 2 and 3 are used, and each run ends with a mid-frame disable. These runs cover the exact load length, the bit order, the frame period and the discard of partial frames.

// File: rtl/serial_gpio_pkg.sv
package serial_gpio_pkg;
  localparam int DATA_W  = 32;
  localparam int DIV_W   = 16;
  localparam int DIV_LSB = 16;
  localparam int CNT_LSB = 6;
  localparam int EN_BIT  = 0;

  typedef enum logic [1:0] {
    RGN_CTRL = 2'd0,
    RGN_OUT  = 2'd1,
    RGN_IN   = 2'd2,
    RGN_RSVD = 2'd3
  } region_e;
endpackage

// File: rtl/sgm_regs.sv
module sgm_regs
  import serial_gpio_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int MAX_PINS = 120,
  parameter int WORDS    = 4,
  parameter int WIDX_W   = 2,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [MAX_PINS-1:0] in_vec,
  output logic [DATA_W-1:0]   rdata,
  output logic [DIV_W-1:0]    div,
  output logic [CNT_W-1:0]    groups,
  output logic                en,
  output logic [MAX_PINS-1:0] out_vec
);
  region_e             rgn;
  logic [WIDX_W-1:0]   idx;
  logic                ctrl_we, out_we, idx_ok;
  logic [DIV_W-1:0]    div_q, div_d;
  logic [CNT_W-1:0]    grp_q, grp_d;
  logic                en_q, en_d;
  logic [MAX_PINS-1:0] out_q, out_d;
  logic [WORDS*DATA_W-1:0] out_pad, in_pad;
  logic [DATA_W-1:0]   ctrl_rd;

  assign rgn     = region_e'(addr[ADDR_W-1 -: 2]);
  assign idx     = addr[WIDX_W-1:0];
  assign idx_ok  = int'(idx) < WORDS;
  assign ctrl_we = wr && (rgn == RGN_CTRL);
  assign out_we  = wr && (rgn == RGN_OUT) && idx_ok;

  always_comb begin
    div_d = div_q;
    grp_d = grp_q;
    en_d  = en_q;
    if (ctrl_we) begin
      div_d = wdata[DIV_LSB +: DIV_W];
      grp_d = wdata[CNT_LSB +: CNT_W];
      en_d  = wdata[EN_BIT];
    end
  end

  for (genvar i = 0; i < MAX_PINS; i++) begin : g_out
    assign out_d[i] = (out_we && (idx == WIDX_W'(i / DATA_W))) ? wdata[i % DATA_W] : out_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      grp_q <= '0;
      en_q  <= 1'b0;
      out_q <= '0;
    end else begin
      div_q <= div_d;
      grp_q <= grp_d;
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    out_pad = '0;
    out_pad[MAX_PINS-1:0] = out_q;
    in_pad = '0;
    in_pad[MAX_PINS-1:0] = in_vec;
    ctrl_rd = '0;
    ctrl_rd[DIV_LSB +: DIV_W] = div_q;
    ctrl_rd[CNT_LSB +: CNT_W] = grp_q;
    ctrl_rd[EN_BIT] = en_q;
  end

  always_comb begin
    rdata = '0;
    case (rgn)
      RGN_CTRL: rdata = ctrl_rd;
      RGN_OUT:  if (idx_ok) rdata = out_pad[idx*DATA_W +: DATA_W];
      RGN_IN:   if (idx_ok) rdata = in_pad[idx*DATA_W +: DATA_W];
      default:  rdata = '0;
    endcase
  end

  assign div     = div_q;
  assign groups  = grp_q;
  assign en      = en_q;
  assign out_vec = out_q;

  // R9
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (rgn == RGN_OUT) && (idx == '0)) |=> (out_vec[0] == $past(wdata[0])));
endmodule

// File: rtl/sgm_clkgen.sv
module sgm_clkgen
  import serial_gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             half;

  assign half = en && (cnt_q >= div);

  always_comb begin
    cnt_d  = cnt_q + 16'd1;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (half) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = half && !sclk_q;
  assign fall_stb = half && sclk_q;

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk);
  // R3
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> ($past(en) && ($past(cnt_q) >= $past(div))));
endmodule

// File: rtl/sgm_shifter.sv
module sgm_shifter #(
  parameter int CNT_W    = 4,
  parameter int MAX_PINS = 120,
  parameter int BIT_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CNT_W-1:0]    groups,
  input  logic                rise_stb,
  input  logic                fall_stb,
  input  logic                sdin,
  input  logic [MAX_PINS-1:0] out_vec,
  output logic                sload,
  output logic                sdout,
  output logic [MAX_PINS-1:0] in_vec
);
  logic [BIT_W-1:0]    n_cur;
  logic                load_q, load_d;
  logic [BIT_W-1:0]    idx_q, idx_d;
  logic [BIT_W-1:0]    nbits_q, nbits_d;
  logic                sdout_q, sdout_d;
  logic                commit;
  logic [MAX_PINS-1:0] cap_q, cap_d, in_q, in_d;

  assign n_cur = {groups, 3'b000};

  always_comb begin
    load_d  = load_q;
    idx_d   = idx_q;
    nbits_d = nbits_q;
    sdout_d = sdout_q;
    commit  = 1'b0;
    if (!en) begin
      load_d  = 1'b1;
      idx_d   = '0;
      sdout_d = 1'b0;
    end else if (fall_stb) begin
      if (load_q) begin
        nbits_d = n_cur;
        if (n_cur != '0) begin
          load_d  = 1'b0;
          idx_d   = n_cur - 1'b1;
          sdout_d = out_vec[n_cur - 1'b1];
        end
      end else if (idx_q == '0) begin
        load_d  = 1'b1;
        commit  = 1'b1;
        sdout_d = 1'b0;
      end else begin
        idx_d   = idx_q - 1'b1;
        sdout_d = out_vec[idx_q - 1'b1];
      end
    end
  end

  for (genvar i = 0; i < MAX_PINS; i++) begin : g_bit
    assign cap_d[i] = (en && rise_stb && !load_q && (idx_q == BIT_W'(i))) ? sdin : cap_q[i];
    assign in_d[i]  = (commit && (BIT_W'(i) < nbits_q)) ? cap_q[i] : in_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b1;
      idx_q   <= '0;
      nbits_q <= '0;
      sdout_q <= 1'b0;
      cap_q   <= '0;
      in_q    <= '0;
    end else begin
      load_q  <= load_d;
      idx_q   <= idx_d;
      nbits_q <= nbits_d;
      sdout_q <= sdout_d;
      cap_q   <= cap_d;
      in_q    <= in_d;
    end
  end

  assign sload  = en && load_q;
  assign sdout  = sdout_q;
  assign in_vec = in_q;

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load_q) |-> (idx_q < nbits_q));
endmodule

// File: rtl/serial_gpio_master.sv
module serial_gpio_master
  import serial_gpio_pkg::*;
#(
  parameter  int CNT_W    = 4,
  localparam int MAX_PINS = ((1 << CNT_W) - 1) * 8,
  localparam int WORDS    = (MAX_PINS + DATA_W - 1) / DATA_W,
  localparam int WIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W   = WIDX_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                sclk,
  output logic                sload,
  output logic                sdout,
  input  logic                sdin,
  output logic [MAX_PINS-1:0] par_out,
  output logic [MAX_PINS-1:0] par_in
);
  localparam int BIT_W = CNT_W + 3;

  logic [1:0]       rst_sync;
  logic             rst_s;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] groups;
  logic             en, rise_stb, fall_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  sgm_regs #(
    .CNT_W(CNT_W), .MAX_PINS(MAX_PINS), .WORDS(WORDS), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_s), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .in_vec(par_in), .rdata(reg_rdata), .div(div), .groups(groups), .en(en),
    .out_vec(par_out)
  );

  sgm_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_s), .en(en), .div(div),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  sgm_shifter #(
    .CNT_W(CNT_W), .MAX_PINS(MAX_PINS), .BIT_W(BIT_W)
  ) u_shifter (
    .clk(clk), .rst_n(rst_s), .en(en), .groups(groups), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .sdin(sdin), .out_vec(par_out), .sload(sload),
    .sdout(sdout), .in_vec(par_in)
  );

  // R4
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($fell(sload) && en) |-> $fell(sclk));
  // R7
  commit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(par_in) |-> $rose(sload));
endmodule

// File: tb/serial_gpio_master_tb.sv
`timescale 1ns/1ps
module serial_gpio_master_tb;
  localparam int CNT_W = 2;
  localparam logic [2:0] A_CTRL = 3'b000;
  localparam logic [2:0] A_OUT  = 3'b010;
  localparam logic [2:0] A_IN   = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sclk, sload, sdout, sdin;
  logic [23:0] par_out, par_in;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [23:0] exp_in = '0;

  always #4 clk = ~clk;

  serial_gpio_master #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .sload(sload),
    .sdout(sdout), .sdin(sdin), .par_out(par_out), .par_in(par_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_CTRL, d);
    chk(d == 32'h0, "R1 ctrl after reset", d, 32'h0);
    chk(!sclk && !sload && !sdout, "R2 serial pins after reset", {sclk, sload, sdout}, 0);
    chk(par_in == 24'h0, "R7 par_in after reset", par_in, 0);
    chk(par_out == 24'h0, "R9 par_out after reset", par_out, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr_reg(A_CTRL, 32'hFFFF_FFFE);
    rd_reg(A_CTRL, d);
    chk(d == 32'hFFFF_00C0, "R1 unused ctrl bits read 0", d, 32'hFFFF_00C0);
    wr_reg(A_CTRL, 32'h0005_0040);
    rd_reg(A_CTRL, d);
    chk(d == 32'h0005_0040, "R1 ctrl readback", d, 32'h0005_0040);
  endtask

  task automatic t_idle();
    logic [31:0] d;
    int bad = 0;
    wr_reg(A_CTRL, 32'h0002_00C0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk || sload || sdout) bad++;
    end
    chk(bad == 0, "R2 idle while disabled", bad, 0);
    wr_reg(A_IN, 32'h00FF_FFFF);
    rd_reg(A_IN, d);
    chk(d == 32'h0, "R9 input region write ignored", d, 0);
    wr_reg(A_OUT, 32'hFFFF_FFFF);
    rd_reg(A_OUT, d);
    chk(d == 32'h00FF_FFFF, "R9 output readback clipped", d, 32'h00FF_FFFF);
    chk(par_out == 24'hFF_FFFF, "R9 par_out follows cache", par_out, 24'hFF_FFFF);
  endtask

  task automatic run_frames(input int div, input int groups,
                            input logic [23:0] opat, input logic [23:0] p1, input logic [23:0] p2);
    int n, per, s, run, lrun, rises, last_rise, cnt, limit;
    int hl_bad, ld_bad, len_bad, st_bad, idle_bad;
    logic [23:0] mask, exp1, exp2, rx, pat;
    logic [31:0] d, ctrl;
    logic psclk, pload;
    n = groups * 8;
    per = 2 * (div + 1);
    mask = (24'h1 << n) - 24'h1;
    exp1 = (exp_in & ~mask) | (p1 & mask);
    exp2 = (exp1 & ~mask) | (p2 & mask);
    ctrl = (32'(div) << 16) | (32'(groups) << 6);
    wr_reg(A_OUT, {8'h00, opat});
    rd_reg(A_OUT, d);
    chk(d == {8'h00, opat}, "R9 output cache readback", d, {8'h00, opat});
    pat = p1;
    sdin = pat[n-1];
    s = 0; run = 0; lrun = 0; rises = 0; last_rise = 0; cnt = 0; rx = '0;
    hl_bad = 0; ld_bad = 0; len_bad = 0; st_bad = 0;
    psclk = 1'b0; pload = 1'b0;
    limit = 4 * (n + 1) * per + 50;
    wr_reg(A_CTRL, ctrl | 32'h1);
    while (s < limit) begin
      rd_reg(A_IN, d);
      if (sclk != psclk) begin
        if (run != div + 1) hl_bad++;
        run = 1;
      end else run++;
      if (sload) lrun++;
      if (pload && !sload) begin
        if (lrun != per) ld_bad++;
        lrun = 0;
      end
      if (sload && !pload) begin
        rises++;
        if (rises >= 2 && (s - last_rise) != (n + 1) * per) len_bad++;
        last_rise = s;
        if (rises == 2) begin
          chk((rx & mask) == (opat & mask), "R5 shifted-out bits", rx & mask, opat & mask);
          chk(d[23:0] == exp1, "R6 captured input word", d, exp1);
          pat = p2;
        end
        if (rises == 3) begin
          chk(d[23:0] == exp2, "R7 input word after second frame", d, exp2);
          break;
        end
        cnt = 0;
      end else if (rises == 2 && d[23:0] != exp1) st_bad++;
      if (sclk && !psclk && !sload && cnt < n) begin
        rx[n-1-cnt] = sdout;
        cnt++;
      end
      sdin = (cnt < n) ? pat[n-1-cnt] : 1'b0;
      psclk = sclk;
      pload = sload;
      s++;
      @(negedge clk);
    end
    chk(rises == 3, "R10 frames repeat", rises, 3);
    chk(hl_bad == 0, "R3 half period", hl_bad, 0);
    chk(ld_bad == 0, "R4 load pulse length", ld_bad, 0);
    chk(len_bad == 0, "R10 frame period", len_bad, 0);
    chk(st_bad == 0, "R7 input word stable mid-frame", st_bad, 0);
    sdin = 1'b1;
    repeat ((n / 2 + 1) * per) @(negedge clk);
    wr_reg(A_CTRL, ctrl);
    @(negedge clk);
    idle_bad = 0;
    for (int i = 0; i < 3 * per + 5; i++) begin
      @(negedge clk);
      if (sclk || sload || sdout) idle_bad++;
    end
    chk(idle_bad == 0, "R2 idle after disable", idle_bad, 0);
    rd_reg(A_IN, d);
    chk(d[23:0] == exp2, "R7 partial frame discarded", d, exp2);
    exp_in = exp2;
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; sdin = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_idle();
    run_frames(0, 3, 24'hA5_3C_96, 24'h3C_5A_C3, 24'h81_7E_42);
    run_frames(2, 2, 24'h00_12_34, 24'h00_BE_EF, 24'h00_12_35);
    rd_reg(A_IN, d);
    chk(d[23:16] == 8'h81, "R8 upper input byte retained", d[23:16], 8'h81);
    run_frames(1, 1, 24'h00_00_5B, 24'h00_00_C6, 24'h00_00_39);
    rd_reg(A_IN, d);
    chk(d[23:8] == 16'h8112, "R8 upper input bytes retained", d[23:8], 16'h8112);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule